// File: doc/BRIEF.md
# Segmented Logical Address Translator

This block turns a logical address, made of a segment selector and a byte offset, into a linear address. It holds a table of sixteen segment descriptors and six segment registers: one for code, one for data, one for stack and three spare ones. Each descriptor gives a base, a limit, three permission bits (execute, read, write) and a privilege level. A request does not name its segment register. The block infers the register from the kind of access. Ordinary loads and stores can name one of the three spare registers instead.

For each request the block reads the selector from the chosen register and uses it as an index into the descriptor table. It checks the offset against the limit, the access kind against the permissions and the caller's privilege against the descriptor's privilege. If every check passes, it returns the offset plus the base one clock later. If a check fails, it returns a fault code. Software fills the table through a write port and fills the segment registers through a load port. The code register accepts a new selector only when the load is flagged as a call, an interrupt or a task switch.

Top module: `segXlate`

## Requirements
- R1: A request sampled on a rising edge gives, after that edge, rspValid=1 and rspLinear = (reqOff + base) mod 2^32, with rspFault=0 (no fault). Back-to-back requests each give one response.
- R2: reqKind selects the segment register. 0=fetch and 1=branch target use the code register. 2=push and 3=pop use the stack register. 4=load, 5=store, 6 and 7 (treated as load) use the data register. Segment-register numbers are 0=code, 1=data, 2=stack, 3/4/5=spare A/B/C.
- R3: For load and store kinds, reqExtra=1/2/3 selects spare register A/B/C in place of the data register, and reqExtra=0 selects the data register. For all other kinds reqExtra is ignored.
- R4: An offset greater than the descriptor limit gives fault code 2 (limit). An offset equal to the limit passes.
- R5: A store or push needs write permission. A load or pop needs read permission. A fetch or branch needs execute permission. A missing permission gives fault code 3 (rights).
- R6: When reqCpl is numerically greater than the descriptor privilege, the block gives fault code 4 (privilege).
- R7: A selector value of NUM_DESC (16) or more gives fault code 1 (invalid selector). Selector 15 is valid.
- R8: Fault priority, highest first, is invalid selector, privilege, rights, limit. A faulted response carries rspLinear=0.
- R9: A segment-register load with ldSeg=0 (code) changes the register only when ldViaCall=1. Otherwise the load is rejected and the register keeps its value. ldSeg values 6 and 7 are ignored.
- R10: After reset, rspValid=0 and rspFault=0. All registers hold selector 0, and every descriptor is zero (base 0, limit 0, no permissions, privilege 0).
- R11: A descriptor write or segment load on the same edge as a request does not affect that request. Later requests see the new value.
- R12: A cycle without a request gives rspValid=0 and rspFault=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dwValid | input | 1 | Descriptor write strobe |
| dwIdx | input | 4 | Descriptor index to write |
| dwBase | input | 32 | New descriptor base |
| dwLimit | input | 32 | New descriptor limit (largest legal offset) |
| dwExec | input | 1 | New execute permission |
| dwRead | input | 1 | New read permission |
| dwWrite | input | 1 | New write permission |
| dwDpl | input | 2 | New descriptor privilege level |
| ldValid | input | 1 | Segment-register load strobe |
| ldSeg | input | 3 | Target register number |
| ldSel | input | 16 | Selector to load |
| ldViaCall | input | 1 | Load comes from a call, interrupt or task switch |
| reqValid | input | 1 | Translation request strobe |
| reqKind | input | 3 | Access kind |
| reqExtra | input | 2 | Spare register choice for loads and stores |
| reqOff | input | 32 | Offset within the segment |
| reqCpl | input | 2 | Current privilege level |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspLinear | output | 32 | Linear address, zero on fault |
| rspFault | output | 3 | Fault code (0 none, 1 selector, 2 limit, 3 rights, 4 privilege) |

## Verification
A corrupted segment register or descriptor shows up on the first request that resolves to it. That response carries the wrong linear address or an unexpected fault code exactly one cycle after the request, so the scoreboard catches it on that response. A wrong register-selection decode appears at once as a base taken from a different descriptor, because every descriptor in the test has a distinct base. Errors in fault ordering appear only on requests that break several checks at once, so the bench includes such requests. A dropped or extra response surfaces on the same cycle as a queue mismatch.

// File: rtl/segXlatePkg.sv
package segXlatePkg;
  parameter int ADDR_W = 32;
  parameter int SEL_W = 16;
  parameter int NUM_SEG = 6;
  parameter int SEG_W = 3;
  parameter int FLT_W = 3;

  localparam logic [SEG_W-1:0] SEG_CODE = 3'd0;
  localparam logic [SEG_W-1:0] SEG_DATA = 3'd1;
  localparam logic [SEG_W-1:0] SEG_STACK = 3'd2;
  localparam logic [SEG_W-1:0] SEG_SPARE0 = 3'd3;

  localparam logic [2:0] KIND_FETCH = 3'd0;
  localparam logic [2:0] KIND_BRANCH = 3'd1;
  localparam logic [2:0] KIND_PUSH = 3'd2;
  localparam logic [2:0] KIND_POP = 3'd3;
  localparam logic [2:0] KIND_STORE = 3'd5;

  localparam logic [FLT_W-1:0] FLT_NONE = 3'd0;
  localparam logic [FLT_W-1:0] FLT_BADSEL = 3'd1;
  localparam logic [FLT_W-1:0] FLT_LIMIT = 3'd2;
  localparam logic [FLT_W-1:0] FLT_RIGHTS = 3'd3;
  localparam logic [FLT_W-1:0] FLT_PRIV = 3'd4;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic canExec;
    logic canRead;
    logic canWrite;
    logic [1:0] dpl;
  } segDesc_t;

  typedef struct packed {
    logic segWe;
    logic [SEG_W-1:0] segDst;
    logic rspFire;
    logic [FLT_W-1:0] fault;
  } ctlStrobes_t;
endpackage

// File: rtl/segXlateCtl.sv
module segXlateCtl
  import segXlatePkg::*;
(
  input  logic reqValid,
  input  logic [2:0] reqKind,
  input  logic [1:0] reqExtra,
  input  logic [1:0] reqCpl,
  input  logic ldValid,
  input  logic [SEG_W-1:0] ldSeg,
  input  logic ldViaCall,
  input  logic selBad,
  input  logic overLimit,
  input  logic descExec,
  input  logic descRead,
  input  logic descWrite,
  input  logic [1:0] descDpl,
  output logic [SEG_W-1:0] reqSeg,
  output ctlStrobes_t strobes
);
  logic isCode;
  logic isStack;
  logic isWrite;
  logic rightsOk;

  always_comb begin
    isCode = (reqKind == KIND_FETCH) || (reqKind == KIND_BRANCH);
    isStack = (reqKind == KIND_PUSH) || (reqKind == KIND_POP);
    if (isCode) reqSeg = SEG_CODE;
    else if (isStack) reqSeg = SEG_STACK;
    else if (reqExtra == 2'd0) reqSeg = SEG_DATA;
    else reqSeg = SEG_SPARE0 + SEG_W'(reqExtra) - SEG_W'(1);
  end

  always_comb begin
    isWrite = (reqKind == KIND_PUSH) || (reqKind == KIND_STORE);
    if (isCode) rightsOk = descExec;
    else if (isWrite) rightsOk = descWrite;
    else rightsOk = descRead;

    strobes.segWe = ldValid && (32'(ldSeg) < NUM_SEG) &&
                    ((ldSeg != SEG_CODE) || ldViaCall);
    strobes.segDst = ldSeg;
    strobes.rspFire = reqValid;
    if (selBad) strobes.fault = FLT_BADSEL;
    else if (reqCpl > descDpl) strobes.fault = FLT_PRIV;
    else if (!rightsOk) strobes.fault = FLT_RIGHTS;
    else if (overLimit) strobes.fault = FLT_LIMIT;
    else strobes.fault = FLT_NONE;
  end
endmodule

// File: rtl/segXlateDp.sv
module segXlateDp
  import segXlatePkg::*;
#(
  parameter int NUM_DESC = 16,
  localparam int IDX_W = $clog2(NUM_DESC)
) (
  input  logic clk,
  input  logic rstN,
  input  logic dwValid,
  input  logic [IDX_W-1:0] dwIdx,
  input  segDesc_t dwDesc,
  input  logic [SEL_W-1:0] ldSel,
  input  logic [SEG_W-1:0] reqSeg,
  input  logic [ADDR_W-1:0] reqOff,
  input  ctlStrobes_t strobes,
  output logic selBad,
  output logic overLimit,
  output logic descExec,
  output logic descRead,
  output logic descWrite,
  output logic [1:0] descDpl,
  output logic rspValid,
  output logic [ADDR_W-1:0] rspLinear,
  output logic [FLT_W-1:0] rspFault
);
  logic [SEL_W-1:0] segRegs [NUM_SEG];
  segDesc_t descTab [NUM_DESC];
  logic [SEL_W-1:0] curSel;
  segDesc_t curDesc;
  logic [ADDR_W-1:0] linSum;

  for (genvar g = 0; g < NUM_DESC; g++) begin : gDesc
    always_ff @(posedge clk) begin
      if (!rstN) descTab[g] <= '0;
      else if (dwValid && dwIdx == IDX_W'(g)) descTab[g] <= dwDesc;
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : gSeg
    always_ff @(posedge clk) begin
      if (!rstN) segRegs[s] <= '0;
      else if (strobes.segWe && strobes.segDst == SEG_W'(s)) segRegs[s] <= ldSel;
    end
  end

  always_comb begin
    curSel = (32'(reqSeg) < NUM_SEG) ? segRegs[reqSeg] : '0;
    selBad = 32'(curSel) >= NUM_DESC;
    curDesc = descTab[curSel[IDX_W-1:0]];
    overLimit = reqOff > curDesc.limit;
    descExec = curDesc.canExec;
    descRead = curDesc.canRead;
    descWrite = curDesc.canWrite;
    descDpl = curDesc.dpl;
    linSum = reqOff + curDesc.base;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspLinear <= '0;
      rspFault <= FLT_NONE;
    end else begin
      rspValid <= strobes.rspFire;
      rspFault <= strobes.rspFire ? strobes.fault : FLT_NONE;
      rspLinear <= (strobes.rspFire && strobes.fault == FLT_NONE) ? linSum : '0;
    end
  end
endmodule

// File: rtl/segXlate.sv
module segXlate
  import segXlatePkg::*;
#(
  parameter int NUM_DESC = 16,
  localparam int IDX_W = $clog2(NUM_DESC)
) (
  input  logic clk,
  input  logic rstN,
  input  logic dwValid,
  input  logic [IDX_W-1:0] dwIdx,
  input  logic [ADDR_W-1:0] dwBase,
  input  logic [ADDR_W-1:0] dwLimit,
  input  logic dwExec,
  input  logic dwRead,
  input  logic dwWrite,
  input  logic [1:0] dwDpl,
  input  logic ldValid,
  input  logic [SEG_W-1:0] ldSeg,
  input  logic [SEL_W-1:0] ldSel,
  input  logic ldViaCall,
  input  logic reqValid,
  input  logic [2:0] reqKind,
  input  logic [1:0] reqExtra,
  input  logic [ADDR_W-1:0] reqOff,
  input  logic [1:0] reqCpl,
  output logic rspValid,
  output logic [ADDR_W-1:0] rspLinear,
  output logic [FLT_W-1:0] rspFault
);
  segDesc_t dwDesc;
  ctlStrobes_t strobes;
  logic [SEG_W-1:0] reqSeg;
  logic selBad, overLimit, descExec, descRead, descWrite;
  logic [1:0] descDpl;

  assign dwDesc = '{base: dwBase, limit: dwLimit, canExec: dwExec,
                    canRead: dwRead, canWrite: dwWrite, dpl: dwDpl};

  segXlateCtl ctlI (
    .reqValid(reqValid), .reqKind(reqKind), .reqExtra(reqExtra), .reqCpl(reqCpl),
    .ldValid(ldValid), .ldSeg(ldSeg), .ldViaCall(ldViaCall),
    .selBad(selBad), .overLimit(overLimit), .descExec(descExec),
    .descRead(descRead), .descWrite(descWrite), .descDpl(descDpl),
    .reqSeg(reqSeg), .strobes(strobes)
  );

  segXlateDp #(.NUM_DESC(NUM_DESC)) dpI (
    .clk(clk), .rstN(rstN), .dwValid(dwValid), .dwIdx(dwIdx), .dwDesc(dwDesc),
    .ldSel(ldSel), .reqSeg(reqSeg), .reqOff(reqOff), .strobes(strobes),
    .selBad(selBad), .overLimit(overLimit), .descExec(descExec),
    .descRead(descRead), .descWrite(descWrite), .descDpl(descDpl),
    .rspValid(rspValid), .rspLinear(rspLinear), .rspFault(rspFault)
  );
endmodule

// File: rtl/segXlateChk.sv
module segXlateChk
  import segXlatePkg::*;
(
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic rspValid,
  input logic [ADDR_W-1:0] rspLinear,
  input logic [FLT_W-1:0] rspFault
);
  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  // R12
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && rspFault == FLT_NONE));
  // R8
  fault_zero_lin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != FLT_NONE) |-> rspLinear == '0);
  // R8
  fault_code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspFault <= FLT_PRIV);
endmodule

bind segXlate segXlateChk chkI (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .rspValid(rspValid),
  .rspLinear(rspLinear), .rspFault(rspFault)
);

// File: tb/segXlate_tb_top.sv
`timescale 1ns/1ps
module segXlate_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dwValid = 0; logic [3:0] dwIdx = 0;
  logic [31:0] dwBase = 0, dwLimit = 0;
  logic dwExec = 0, dwRead = 0, dwWrite = 0; logic [1:0] dwDpl = 0;
  logic ldValid = 0; logic [2:0] ldSeg = 0; logic [15:0] ldSel = 0; logic ldViaCall = 0;
  logic reqValid = 0; logic [2:0] reqKind = 0; logic [1:0] reqExtra = 0;
  logic [31:0] reqOff = 0; logic [1:0] reqCpl = 0;
  logic rspValid; logic [31:0] rspLinear; logic [2:0] rspFault;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] expLin[$];
  logic [2:0] expFlt[$];
  string expTag[$];

  always #10 clk = ~clk;

  segXlate dut_i (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReq(input logic [2:0] k, input logic [1:0] ex, input logic [31:0] off,
                       input logic [1:0] cpl, input logic [31:0] lin, input logic [2:0] flt,
                       input string tag);
    reqValid = 1; reqKind = k; reqExtra = ex; reqOff = off; reqCpl = cpl;
    expLin.push_back(lin); expFlt.push_back(flt); expTag.push_back(tag);
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic writeDesc(input logic [3:0] idx, input logic [31:0] base, input logic [31:0] lim,
                           input logic x, input logic r, input logic w, input logic [1:0] dpl);
    dwValid = 1; dwIdx = idx; dwBase = base; dwLimit = lim;
    dwExec = x; dwRead = r; dwWrite = w; dwDpl = dpl;
    @(negedge clk);
    dwValid = 0;
  endtask

  task automatic loadSeg(input logic [2:0] seg, input logic [15:0] sel, input logic via);
    ldValid = 1; ldSeg = seg; ldSel = sel; ldViaCall = via;
    @(negedge clk);
    ldValid = 0;
  endtask

  // scoreboard monitor
  initial forever begin
    @(posedge clk); #1;
    if (rstN) begin
      if (rspValid) begin
        if (expLin.size() == 0) check(0, "R12 spurious response", 64'(rspValid), 64'(0));
        else begin
          logic [31:0] l; logic [2:0] f; string t;
          l = expLin.pop_front(); f = expFlt.pop_front(); t = expTag.pop_front();
          check(rspLinear == l && rspFault == f, t, {29'(0), rspFault, rspLinear}, {29'(0), f, l});
        end
      end else if (expLin.size() != 0) begin
        check(0, {expTag[0], " missing response"}, 64'(0), 64'(1));
        void'(expLin.pop_front()); void'(expFlt.pop_front()); void'(expTag.pop_front());
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rspValid == 0 && rspFault == 0, "R10 reset outputs", {rspValid, rspFault}, 0);
    rstN = 1;
    // R10: descriptor 0 is empty, so a load through data register lacks read rights
    doReq(3'd4, 2'd0, 32'h0, 2'd0, 32'h0, 3'd3, "R10 reset descriptor");
    writeDesc(4'd1, 32'h1000_0000, 32'h0000_FFFF, 1, 1, 0, 2'd0);
    writeDesc(4'd2, 32'h2000_0000, 32'h0000_0FFF, 0, 1, 1, 2'd3);
    writeDesc(4'd3, 32'h3000_0000, 32'h0000_00FF, 0, 1, 1, 2'd0);
    writeDesc(4'd4, 32'hFFFF_F000, 32'hFFFF_FFFF, 0, 1, 1, 2'd3);
    writeDesc(4'd5, 32'h0000_0500, 32'h0000_0010, 0, 1, 0, 2'd3);
    writeDesc(4'd6, 32'h0000_6000, 32'h0000_0000, 0, 1, 0, 2'd0);
    loadSeg(3'd0, 16'd1, 1); loadSeg(3'd1, 16'd2, 0); loadSeg(3'd2, 16'd3, 0);
    loadSeg(3'd3, 16'd4, 0); loadSeg(3'd4, 16'd5, 0); loadSeg(3'd5, 16'd20, 0);
    loadSeg(3'd6, 16'd0, 0); // R9 ignored register number
    doReq(3'd0, 2'd0, 32'h10, 2'd0, 32'h1000_0010, 3'd0, "R1 R2 fetch via code");
    doReq(3'd0, 2'd1, 32'h20, 2'd0, 32'h1000_0020, 3'd0, "R3 extra ignored on fetch");
    doReq(3'd1, 2'd0, 32'hFFFF, 2'd0, 32'h1000_FFFF, 3'd0, "R4 offset equals limit");
    doReq(3'd1, 2'd0, 32'h1_0000, 2'd0, 32'h0, 3'd2, "R4 offset over limit");
    doReq(3'd4, 2'd0, 32'h123, 2'd3, 32'h2000_0123, 3'd0, "R2 load via data");
    doReq(3'd5, 2'd0, 32'hFFF, 2'd3, 32'h2000_0FFF, 3'd0, "R2 store via data");
    doReq(3'd5, 2'd0, 32'h1000, 2'd3, 32'h0, 3'd2, "R4 store over limit");
    doReq(3'd2, 2'd0, 32'h40, 2'd0, 32'h3000_0040, 3'd0, "R2 push via stack");
    doReq(3'd2, 2'd0, 32'h40, 2'd3, 32'h0, 3'd4, "R6 privilege fault");
    doReq(3'd3, 2'd0, 32'h40, 2'd0, 32'h3000_0040, 3'd0, "R2 pop via stack");
    doReq(3'd2, 2'd3, 32'h44, 2'd0, 32'h3000_0044, 3'd0, "R3 extra ignored on push");
    doReq(3'd7, 2'd0, 32'h8, 2'd3, 32'h2000_0008, 3'd0, "R2 reserved kind as load");
    doReq(3'd4, 2'd1, 32'h2000, 2'd3, 32'h0000_1000, 3'd0, "R1 R3 spare A wraps");
    doReq(3'd5, 2'd2, 32'h8, 2'd3, 32'h0, 3'd3, "R5 store without write");
    doReq(3'd4, 2'd2, 32'h8, 2'd3, 32'h0000_0508, 3'd0, "R3 load via spare B");
    doReq(3'd5, 2'd2, 32'h20, 2'd3, 32'h0, 3'd3, "R8 rights over limit");
    doReq(3'd4, 2'd3, 32'h0, 2'd3, 32'h0, 3'd1, "R7 R8 invalid selector first");
    loadSeg(3'd5, 16'd16, 0);
    doReq(3'd4, 2'd3, 32'h0, 2'd0, 32'h0, 3'd1, "R7 selector 16 invalid");
    loadSeg(3'd5, 16'd15, 0);
    doReq(3'd4, 2'd3, 32'h0, 2'd0, 32'h0, 3'd3, "R7 selector 15 valid");
    loadSeg(3'd0, 16'd3, 0);
    doReq(3'd0, 2'd0, 32'h10, 2'd0, 32'h1000_0010, 3'd0, "R9 code load rejected");
    loadSeg(3'd0, 16'd2, 1);
    doReq(3'd0, 2'd0, 32'h10, 2'd3, 32'h0, 3'd3, "R5 R9 fetch without execute");
    loadSeg(3'd0, 16'd1, 1);
    loadSeg(3'd4, 16'd6, 0);
    doReq(3'd5, 2'd2, 32'h5, 2'd2, 32'h0, 3'd4, "R8 privilege over rights and limit");
    // R11: descriptor rewrite on the request edge
    dwValid = 1; dwIdx = 4'd2; dwBase = 32'h2800_0000; dwLimit = 32'hFFF;
    dwExec = 0; dwRead = 1; dwWrite = 1; dwDpl = 2'd3;
    ldValid = 1; ldSeg = 3'd1; ldSel = 16'd3; ldViaCall = 0;
    doReq(3'd4, 2'd0, 32'h4, 2'd3, 32'h2000_0004, 3'd0, "R11 same-edge writes unseen");
    dwValid = 0; ldValid = 0;
    loadSeg(3'd1, 16'd2, 0);
    doReq(3'd4, 2'd0, 32'h4, 2'd3, 32'h2800_0004, 3'd0, "R11 new base seen later");
    repeat (3) @(negedge clk);
    check(rspValid == 0 && rspFault == 0, "R12 idle outputs", {rspValid, rspFault}, 0);
    check(expLin.size() == 0, "R1 all responses seen", expLin.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule